// File: doc/BRIEF.md
# Overlap-save section framer

This block prepares one receive window of complex samples for sectioned fast convolution, and undoes the sectioning on the processed data. The forward path cuts the window into sections of N points, where N is a power of two. Each section begins with the M most recent stream samples already sent, followed by N−M fresh samples. The first section of a window sees M zeros where that history would be. The section that consumes the last window sample is filled up to N with zeros. Every emitted sample carries the section number, first-section and last-section flags, and an end-of-section mark that a downstream transform can use to frame its input.

The return path takes the processed sections back in the same order. It drops the first M points of each section and forwards the rest as one continuous stream. It stops after exactly the window length, so padding never reaches the output. A start pulse latches the section-size exponent, the overlap and the window length for both paths. The same pulse clears the history count, the pointers and the section counter, so one window never leaks into the next.

Top module: `ols_framer`

## Requirements
- R1: Every emitted section is exactly N = 2^`cfg_log2n` samples long. All of its samples carry the same `sec_index`, counting 0, 1, 2, … within the window. `sec_first` is high only in section 0, and `sec_end` is high only on position N−1.
- R2: In section 0, positions 0 to M−1 are zero (`sec_data` equals 0).
- R3: In section s > 0, positions 0 to M−1 repeat, in order, stream samples s·(N−M)−M through s·(N−M)−1. A position whose stream index is negative is zero; this happens when M exceeds N−M.
- R4: In section s, positions M to N−1 carry stream samples s·(N−M) through s·(N−M)+N−M−1, in arrival order, each appearing one cycle after its input handshake.
- R5: A window of L samples yields ceil(L/(N−M)) sections. `sec_last` is high only in the final section, and every position whose stream index is L or greater is zero.
- R6: `in_ready` is high only while the framer waits for a fresh sample. A low `in_valid` adds a gap in `sec_valid` but no extra or lost sample.
- R7: A start pulse, even in the middle of a window, latches the new configuration and discards all history. The following section 0 again shows M zeros.
- R8: The trimmer discards positions 0 to M−1 of each processed section and forwards positions M to N−1 in order, one cycle after `proc_valid`.
- R9: The trimmer forwards exactly L samples per window and sets `out_last` on the L-th. After that it ignores further `proc_valid` cycles until the next start.
- R10: After reset, and once a window is finished, `sec_valid`, `in_ready` and `out_valid` are low. In that state `in_valid` and `proc_valid` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a window and latches the configuration |
| cfg_log2n | input | $clog2(MAX_LOG2N+1) | Section size exponent, N = 2^cfg_log2n |
| cfg_overlap | input | $clog2(MAX_M+1) | Overlap M, with 1 ≤ M < N and M ≤ MAX_M |
| cfg_win_len | input | LEN_W | Window length L in samples |
| in_valid | input | 1 | A fresh window sample is offered |
| in_ready | output | 1 | The framer takes the offered sample this cycle |
| in_data | input | 2*DW | Window sample, I in the upper half, Q in the lower half |
| sec_valid | output | 1 | A section sample is present |
| sec_data | output | 2*DW | Section sample |
| sec_first | output | 1 | Sample belongs to section 0 |
| sec_last | output | 1 | Sample belongs to the final section |
| sec_end | output | 1 | Sample is position N−1 of its section |
| sec_index | output | LEN_W | Section number within the window |
| proc_valid | input | 1 | A processed section sample is present |
| proc_data | input | 2*DW | Processed section sample, in section order |
| out_valid | output | 1 | A trimmed output sample is present |
| out_data | output | 2*DW | Trimmed output sample |
| out_last | output | 1 | Final sample of the window |

## Verification
The bench builds the block with DW=8, MAX_LOG2N=4, MAX_M=8 and LEN_W=8. With these values every section stays short enough to compare sample by sample, and configurations with N from 4 to 16 become reachable. Those include:
- an overlap larger than the fresh part, where history must be padded with leading zeros;
- a window that is an exact multiple of N−M;
- a window that leaves a padded tail.

The framer output is fed straight back into the return path, so the trimmed stream must equal the original window. An aborted window checks that history is cleared on restart.

// File: rtl/ols_pkg.sv
package ols_pkg;

    // Where the next emitted section sample comes from.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HIST = 2'd1,
        SRC_NEW  = 2'd2,
        SRC_PAD  = 2'd3
    } src_e;

endpackage

// File: rtl/ols_hist_ram.sv
module ols_hist_ram #(
    parameter int SW = 32,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [SW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [SW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [SW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ols_section_gen.sv
module ols_section_gen
    import ols_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MAX_LOG2N = 12,
    parameter int MAX_M     = 128,
    parameter int LEN_W     = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [$clog2(MAX_LOG2N+1)-1:0]   cfg_log2n,
    input  logic [$clog2(MAX_M+1)-1:0]       cfg_overlap,
    input  logic [LEN_W-1:0]                 cfg_win_len,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [2*DW-1:0]                  in_data,
    output logic                             sec_valid,
    output logic [2*DW-1:0]                  sec_data,
    output logic                             sec_first,
    output logic                             sec_last,
    output logic                             sec_end,
    output logic [LEN_W-1:0]                 sec_index
);

    localparam int SW = 2 * DW;
    localparam int PW = MAX_LOG2N + 1;
    localparam int MW = $clog2(MAX_M + 1);
    localparam int HA = (MAX_M > 1) ? $clog2(MAX_M) : 1;

    typedef struct packed {
        logic             busy;
        logic [PW-1:0]    nm1;
        logic [PW-1:0]    m;
        logic [LEN_W-1:0] len;
        logic [PW-1:0]    pos;
        logic [LEN_W-1:0] cons;
        logic [LEN_W-1:0] base;
        logic [LEN_W-1:0] idx;
        logic [HA-1:0]    wp;
        logic [MW-1:0]    wcnt;
        logic             ov;
        logic [SW-1:0]    od;
        logic             ofirst;
        logic             olast;
        logic             oend;
        logic [LEN_W-1:0] oidx;
        logic [PW-1:0]    opos;
    } gen_st_t;

    gen_st_t        s_d, s_q;
    src_e           src_c;
    logic           ready_c;
    logic           we_c;
    logic [HA-1:0]  raddr_c;
    logic [SW-1:0]  rdata_c;
    logic [PW-1:0]  n_new_c;
    logic [LEN_W:0] reach_c;
    logic           is_last_c;
    logic           hist_zero_c;

    ols_hist_ram #(
        .SW (SW),
        .AW (HA)
    ) hist_i (
        .clk   (clk),
        .we    (we_c),
        .waddr (s_q.wp),
        .wdata (in_data),
        .raddr (raddr_c),
        .rdata (rdata_c)
    );

    always_comb begin
        n_new_c     = s_q.nm1 - s_q.m + PW'(1);
        reach_c     = (LEN_W+1)'(s_q.base) + (LEN_W+1)'(n_new_c);
        is_last_c   = (reach_c >= {1'b0, s_q.len});
        raddr_c     = s_q.wp - HA'(s_q.m) + HA'(s_q.pos);
        hist_zero_c = (PW'(s_q.wcnt) < s_q.m) &&
                      (s_q.pos < (s_q.m - PW'(s_q.wcnt)));

        s_d      = s_q;
        s_d.ov   = 1'b0;
        s_d.oend = 1'b0;
        ready_c  = 1'b0;
        we_c     = 1'b0;
        src_c    = SRC_NONE;

        if (start) begin
            s_d.nm1  = (PW'(1) << cfg_log2n) - PW'(1);
            s_d.m    = PW'(cfg_overlap);
            s_d.len  = cfg_win_len;
            s_d.busy = (cfg_win_len != '0);
            s_d.pos  = '0;
            s_d.cons = '0;
            s_d.base = '0;
            s_d.idx  = '0;
            s_d.wp   = '0;
            s_d.wcnt = '0;
        end else if (s_q.busy) begin
            if (s_q.pos < s_q.m) begin
                src_c = SRC_HIST;
            end else if (s_q.cons < s_q.len) begin
                ready_c = 1'b1;
                if (in_valid) begin
                    src_c = SRC_NEW;
                end
            end else begin
                src_c = SRC_PAD;
            end

            if (src_c != SRC_NONE) begin
                s_d.ov     = 1'b1;
                s_d.ofirst = (s_q.idx == '0);
                s_d.olast  = is_last_c;
                s_d.oend   = (s_q.pos == s_q.nm1);
                s_d.oidx   = s_q.idx;
                s_d.opos   = s_q.pos;
                case (src_c)
                    SRC_HIST: s_d.od = hist_zero_c ? '0 : rdata_c;
                    SRC_NEW:  s_d.od = in_data;
                    default:  s_d.od = '0;
                endcase

                if (src_c == SRC_NEW) begin
                    we_c     = 1'b1;
                    s_d.wp   = s_q.wp + HA'(1);
                    s_d.cons = s_q.cons + LEN_W'(1);
                    if (s_q.wcnt != MW'(MAX_M)) begin
                        s_d.wcnt = s_q.wcnt + MW'(1);
                    end
                end

                if (s_q.pos == s_q.nm1) begin
                    s_d.pos  = '0;
                    s_d.idx  = s_q.idx + LEN_W'(1);
                    s_d.base = s_d.cons;
                    if (is_last_c) begin
                        s_d.busy = 1'b0;
                    end
                end else begin
                    s_d.pos = s_q.pos + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = ready_c;
    assign sec_valid = s_q.ov;
    assign sec_data  = s_q.od;
    assign sec_first = s_q.ofirst;
    assign sec_last  = s_q.olast;
    assign sec_end   = s_q.oend;
    assign sec_index = s_q.oidx;

    AST_FIRST_HISTORY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_first && (s_q.opos < s_q.m)) |-> (sec_data == '0))
        else $error("section 0 history not zero"); // R2

    AST_END_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_end) |-> (s_q.opos == s_q.nm1))
        else $error("end mark off the tail position"); // R1

    AST_READY_IN_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (s_q.busy && (s_q.pos >= s_q.m) && (s_q.cons < s_q.len)))
        else $error("ready outside fresh part"); // R6

    AST_STALL_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !start) |=> !sec_valid)
        else $error("sample emitted during input stall"); // R6

endmodule

// File: rtl/ols_trimmer.sv
module ols_trimmer #(
    parameter int DW        = 16,
    parameter int MAX_LOG2N = 12,
    parameter int MAX_M     = 128,
    parameter int LEN_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(MAX_LOG2N+1)-1:0] cfg_log2n,
    input  logic [$clog2(MAX_M+1)-1:0]     cfg_overlap,
    input  logic [LEN_W-1:0]               cfg_win_len,
    input  logic                           proc_valid,
    input  logic [2*DW-1:0]                proc_data,
    output logic                           out_valid,
    output logic [2*DW-1:0]                out_data,
    output logic                           out_last
);

    localparam int SW = 2 * DW;
    localparam int PW = MAX_LOG2N + 1;

    typedef struct packed {
        logic             busy;
        logic [PW-1:0]    nm1;
        logic [PW-1:0]    m;
        logic [LEN_W-1:0] len;
        logic [PW-1:0]    pos;
        logic [LEN_W-1:0] fwd;
        logic             ov;
        logic [SW-1:0]    od;
        logic             olast;
    } trim_st_t;

    trim_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ov    = 1'b0;
        s_d.olast = 1'b0;

        if (start) begin
            s_d.nm1  = (PW'(1) << cfg_log2n) - PW'(1);
            s_d.m    = PW'(cfg_overlap);
            s_d.len  = cfg_win_len;
            s_d.busy = (cfg_win_len != '0);
            s_d.pos  = '0;
            s_d.fwd  = '0;
        end else if (s_q.busy && proc_valid) begin
            if ((s_q.pos >= s_q.m) && (s_q.fwd < s_q.len)) begin
                s_d.ov    = 1'b1;
                s_d.od    = proc_data;
                s_d.olast = (s_q.fwd == (s_q.len - LEN_W'(1)));
                s_d.fwd   = s_q.fwd + LEN_W'(1);
                if (s_d.olast) begin
                    s_d.busy = 1'b0;
                end
            end
            s_d.pos = (s_q.pos == s_q.nm1) ? '0 : s_q.pos + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_last  = s_q.olast;

    AST_SKIP_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && proc_valid && !start && (s_q.pos < s_q.m)) |=> !out_valid)
        else $error("overlap point forwarded"); // R8

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid)
        else $error("output after window end"); // R9

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (s_q.fwd <= s_q.len))
        else $error("forwarded beyond window length"); // R9

endmodule

// File: rtl/ols_framer.sv
module ols_framer #(
    parameter int DW        = 16,
    parameter int MAX_LOG2N = 12,
    parameter int MAX_M     = 128,
    parameter int LEN_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(MAX_LOG2N+1)-1:0] cfg_log2n,
    input  logic [$clog2(MAX_M+1)-1:0]     cfg_overlap,
    input  logic [LEN_W-1:0]               cfg_win_len,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [2*DW-1:0]                in_data,
    output logic                           sec_valid,
    output logic [2*DW-1:0]                sec_data,
    output logic                           sec_first,
    output logic                           sec_last,
    output logic                           sec_end,
    output logic [LEN_W-1:0]               sec_index,
    input  logic                           proc_valid,
    input  logic [2*DW-1:0]                proc_data,
    output logic                           out_valid,
    output logic [2*DW-1:0]                out_data,
    output logic                           out_last
);

    ols_section_gen #(
        .DW        (DW),
        .MAX_LOG2N (MAX_LOG2N),
        .MAX_M     (MAX_M),
        .LEN_W     (LEN_W)
    ) gen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_log2n   (cfg_log2n),
        .cfg_overlap (cfg_overlap),
        .cfg_win_len (cfg_win_len),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .sec_valid   (sec_valid),
        .sec_data    (sec_data),
        .sec_first   (sec_first),
        .sec_last    (sec_last),
        .sec_end     (sec_end),
        .sec_index   (sec_index)
    );

    ols_trimmer #(
        .DW        (DW),
        .MAX_LOG2N (MAX_LOG2N),
        .MAX_M     (MAX_M),
        .LEN_W     (LEN_W)
    ) trim_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_log2n   (cfg_log2n),
        .cfg_overlap (cfg_overlap),
        .cfg_win_len (cfg_win_len),
        .proc_valid  (proc_valid),
        .proc_data   (proc_data),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last)
    );

endmodule

// File: tb/ols_framer_tb_top.sv
module ols_framer_tb_top;

    localparam int DW = 8;
    localparam int MAX_LOG2N = 4;
    localparam int MAX_M = 8;
    localparam int LEN_W = 8;
    localparam int NCFG = 4;
    // log2n, overlap, window length, expected section count
    localparam int CFG [NCFG][4] = '{
        '{3, 3, 12, 3},
        '{3, 5, 7, 3},
        '{4, 6, 10, 1},
        '{2, 1, 9, 3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg_log2n = '0;
    logic [3:0] cfg_overlap = '0;
    logic [LEN_W-1:0] cfg_win_len = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2*DW-1:0] in_data = '0;
    logic sec_valid, sec_first, sec_last, sec_end;
    logic [2*DW-1:0] sec_data;
    logic [LEN_W-1:0] sec_index;
    logic proc_valid = 1'b0;
    logic [2*DW-1:0] proc_data = '0;
    logic out_valid, out_last;
    logic [2*DW-1:0] out_data;

    int checks = 0;
    int failures = 0;

    logic [2*DW-1:0] cap_d [256];
    logic [3:0]      cap_f [256];
    int              cap_i [256];
    int              cap_n = 0;
    logic [2*DW-1:0] res_d [256];
    logic            res_l [256];
    int              res_n = 0;

    always #10 clk = ~clk;

    ols_framer #(
        .DW(DW), .MAX_LOG2N(MAX_LOG2N), .MAX_M(MAX_M), .LEN_W(LEN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_log2n(cfg_log2n), .cfg_overlap(cfg_overlap), .cfg_win_len(cfg_win_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .sec_valid(sec_valid), .sec_data(sec_data), .sec_first(sec_first),
        .sec_last(sec_last), .sec_end(sec_end), .sec_index(sec_index),
        .proc_valid(proc_valid), .proc_data(proc_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    always @(negedge clk) begin
        if (sec_valid && cap_n < 256) begin
            cap_d[cap_n] = sec_data;
            cap_f[cap_n] = {sec_first, sec_last, sec_end, 1'b0};
            cap_i[cap_n] = int'(sec_index);
            cap_n = cap_n + 1;
        end
        if (out_valid && res_n < 256) begin
            res_d[res_n] = out_data;
            res_l[res_n] = out_last;
            res_n = res_n + 1;
        end
    end

    function automatic logic [2*DW-1:0] smp(int j);
        return {8'(j + 1), 8'(j * 3 + 7)};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start(int c);
        @(negedge clk);
        cfg_log2n   = 3'(CFG[c][0]);
        cfg_overlap = 4'(CFG[c][1]);
        cfg_win_len = LEN_W'(CFG[c][2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(int count);
        int idx = 0;
        int cyc = 0;
        while (idx < count && cyc < 2000) begin
            bit hs;
            in_valid = ((cyc % 5) != 3);
            in_data  = smp(idx);
            hs = in_valid && in_ready;
            @(negedge clk);
            if (hs) idx++;
            cyc++;
        end
        in_valid = 1'b0;
    endtask

    task automatic run_cfg(int c, string hist_req);
        int n = 1 << CFG[c][0];
        int m = CFG[c][1];
        int l = CFG[c][2];
        int s_exp = CFG[c][3];
        int nm = n - m;
        do_start(c);
        cap_n = 0;
        res_n = 0;
        feed(l);
        repeat (2 * n + 4) @(negedge clk);
        chk(cap_n == s_exp * n, "R5", "section sample count", cap_n, s_exp * n);
        for (int k = 0; k < cap_n && k < s_exp * n; k++) begin
            int s = k / n;
            int p = k % n;
            int j;
            logic [2*DW-1:0] e;
            logic [3:0] ef;
            string req;
            if (p < m) begin
                j = s * nm - m + p;
                e = (j < 0) ? '0 : smp(j);
                req = (s == 0) ? hist_req : "R3";
            end else begin
                j = s * nm + p - m;
                e = (j < l) ? smp(j) : '0;
                req = (j < l) ? "R4" : "R5";
            end
            chk(cap_d[k] == e, req, "section data", int'(cap_d[k]), int'(e));
            ef = {(s == 0), (s == s_exp - 1), (p == n - 1), 1'b0};
            chk(cap_f[k] == ef, "R1", "first/last/end flags", int'(cap_f[k]), int'(ef));
            chk(cap_i[k] == s, "R1", "section index", cap_i[k], s);
        end
        // loop sections back through the return path
        for (int k = 0; k < cap_n; k++) begin
            if ((k % 4) == 2) begin
                proc_valid = 1'b0;
                @(negedge clk);
            end
            proc_valid = 1'b1;
            proc_data  = cap_d[k];
            @(negedge clk);
        end
        proc_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(res_n == l, "R9", "trimmed sample count", res_n, l);
        for (int j = 0; j < res_n && j < l; j++) begin
            chk(res_d[j] == smp(j), "R8", "trimmed data", int'(res_d[j]), int'(smp(j)));
            chk(res_l[j] == (j == l - 1), "R9", "out_last", int'(res_l[j]), int'(j == l - 1));
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sec_valid && !in_ready && !out_valid, "R10", "reset outputs",
            int'({sec_valid, in_ready, out_valid}), 0);

        for (int c = 0; c < NCFG; c++) begin
            run_cfg(c, "R2");
        end

        // idle: offered samples must do nothing
        cap_n = 0;
        res_n = 0;
        in_valid = 1'b1;
        in_data = 16'hBEEF;
        proc_valid = 1'b1;
        proc_data = 16'h1234;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!in_ready, "R10", "in_ready while idle", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        proc_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(cap_n == 0, "R10", "sections while idle", cap_n, 0);
        chk(res_n == 0, "R9", "output after window end", res_n, 0);

        // abort a window part-way, then restart: history must be clear
        do_start(1);
        feed(5);
        run_cfg(1, "R7");
        do_start(0);
        feed(8);
        run_cfg(0, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule